// File: doc/BRIEF.md
# Memory Controller Status Polling Sequencer

This block drives a half-duplex byte link toward a target device and polls that device's status for a host controller. Two polls are provided. The enable poll sends a single control/status load command, reads one byte back, and repeats until a memory-access-enabled flag appears in the reply, or until a fixed retry limit runs out. The controller-busy poll sends a one-byte direct load command followed by a 32-bit status address, reads one byte back, and repeats the whole five-byte transaction until the busy bit (bit 7) of the reply is clear.

The host starts a poll with a one-cycle start pulse and waits for `done`. That pulse comes with either `ok` (the condition was met) or `timeout` (the attempt budget ran out). The link transceiver sits below. It takes bytes over a valid/ready transmit handshake and returns reply bytes over a valid/ready receive handshake. The opcodes, the register index, the flag position, the address parts and both attempt limits are parameters.

Top module: `mem_poll_seq`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `rx_ready`, `done`, `ok` and `timeout` are all 0.
- R2: One enable-poll attempt sends exactly one byte, `OP_LDCS | STATUS_IDX` (0x80 with defaults), then accepts exactly one reply byte.
- R3: The enable poll ends with `done`=1, `ok`=1 and `timeout`=0 on the first reply with bit `FLAG_BIT` set (bit 1 with defaults). A reply with that bit clear starts a new attempt, whatever its other bits hold.
- R4: After `BUS_RETRIES` (255) replies in a row with the flag clear, the enable poll ends with `done`=1, `timeout`=1 and `ok`=0, and sends no further byte.
- R5: One controller-busy attempt sends five bytes in this order: `OP_LDS | (SIZE_CODE << 2)` (0x00 with defaults), then the address `DATA_BASE | CTRL_BASE | STAT_OFS` (0x010001CF with defaults) with its most significant byte first, i.e. 0x01, 0x00, 0x01, 0xCF.
- R6: The controller-busy poll ends with `ok`=1 on a reply whose bit 7 is 0. A reply with bit 7 set repeats all five bytes and the read.
- R7: When `MAX_BUSY_POLLS` is 0, the controller-busy poll has no limit (more than 255 busy replies still lead to `ok`). When it is N>0, N busy replies in a row end the poll with `timeout`=1.
- R8: `busy` is 1 from the cycle after an accepted start until the cycle after `done`. Start pulses that arrive while `busy` is 1 have no effect on the bytes sent or on the results.
- R9: If both start inputs are high in the same idle cycle, the enable poll runs.
- R10: `tx_data` and `tx_valid` hold steady until `tx_ready` accepts the byte. `rx_ready` rises only after the last byte of an attempt is accepted, and is never high together with `tx_valid`.
- R11: `done` is a one-cycle pulse. `ok` and `timeout` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_bus | input | 1 | Pulse: begin the enable poll |
| start_ctrl | input | 1 | Pulse: begin the controller-busy poll |
| tx_data | output | 8 | Byte offered to the link |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Link accepts the offered byte |
| rx_data | input | 8 | Reply byte from the link |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_ready | output | 1 | Sequencer waits for a reply byte |
| busy | output | 1 | A poll is running |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last poll met its condition |
| timeout | output | 1 | Last poll ran out of attempts |

## Verification
Two things can land in the same cycle. The first is the two start requests, which can arrive together while the block is idle. The second is a start request that arrives while an attempt is still in flight. The bench pulses both starts in one idle cycle and expects only the enable-poll byte stream. During a 255-attempt enable poll, it also pulses both starts again. Any byte or result beyond the expected ones shows up in the scoreboard as a mismatch or an unexpected pop.

// File: rtl/poll_seq_pkg.sv
package poll_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RECV} seq_state_t;
  typedef enum logic {OP_BUS, OP_CTRL} poll_op_t;
endpackage

// File: rtl/poll_frame_rom.sv
module poll_frame_rom
  import poll_seq_pkg::*;
#(
  parameter logic [7:0]  OP_LDCS    = 8'h80,
  parameter logic [3:0]  STATUS_IDX = 4'h0,
  parameter logic [7:0]  OP_LDS     = 8'h00,
  parameter logic [1:0]  SIZE_CODE  = 2'd0,
  parameter logic [31:0] DATA_BASE  = 32'h0100_0000,
  parameter logic [31:0] CTRL_BASE  = 32'h0000_01C0,
  parameter logic [7:0]  STAT_OFS   = 8'h0F
) (
  input  poll_op_t   op,
  input  logic [2:0] idx,
  output logic [7:0] byte_o
);
  localparam logic [31:0] STAT_ADDR = DATA_BASE | CTRL_BASE | {24'h0, STAT_OFS};
  localparam logic [7:0]  BUS_CMD   = OP_LDCS | {4'h0, STATUS_IDX};
  localparam logic [7:0]  CTRL_CMD  = OP_LDS | {4'h0, SIZE_CODE, 2'b00};

  logic [7:0] addr_byte [4];

  // address bytes, most significant first
  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_addr
      assign addr_byte[g] = STAT_ADDR[31-8*g -: 8];
    end
  endgenerate

  always_comb begin
    byte_o = 8'h00;
    if (op == OP_BUS) begin
      byte_o = BUS_CMD;
    end else begin
      case (idx)
        3'd0:    byte_o = CTRL_CMD;
        3'd1:    byte_o = addr_byte[0];
        3'd2:    byte_o = addr_byte[1];
        3'd3:    byte_o = addr_byte[2];
        default: byte_o = addr_byte[3];
      endcase
    end
  end
endmodule

// File: rtl/poll_try_ctr.sv
module poll_try_ctr #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign hit    = inc && (limit != '0) && (cnt_nx == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && !hit && (cnt != '1)) begin
      cnt <= cnt_nx[CNT_W-1:0];
    end
  end

  // R4
  cnt_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/mem_poll_seq.sv
module mem_poll_seq
  import poll_seq_pkg::*;
#(
  parameter logic [7:0]  OP_LDCS        = 8'h80,
  parameter logic [3:0]  STATUS_IDX     = 4'h0,
  parameter int          FLAG_BIT       = 1,
  parameter logic [7:0]  OP_LDS         = 8'h00,
  parameter logic [1:0]  SIZE_CODE      = 2'd0,
  parameter logic [31:0] DATA_BASE      = 32'h0100_0000,
  parameter logic [31:0] CTRL_BASE      = 32'h0000_01C0,
  parameter logic [7:0]  STAT_OFS       = 8'h0F,
  parameter int          BUS_RETRIES    = 255,
  parameter int          MAX_BUSY_POLLS = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_bus,
  input  logic       start_ctrl,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic       timeout
);
  localparam int         LIM_MAX   = (BUS_RETRIES > MAX_BUSY_POLLS) ? BUS_RETRIES : MAX_BUSY_POLLS;
  localparam int         CNT_W     = $clog2(LIM_MAX + 1);
  localparam logic [2:0] BUS_LAST  = 3'd0;
  localparam logic [2:0] CTRL_LAST = 3'd4;
  localparam logic [7:0] FLAG_MASK = 8'(1 << FLAG_BIT);
  localparam logic [7:0] BUSY_MASK = 8'h80;

  seq_state_t state;
  poll_op_t   op;
  logic [2:0] idx;

  poll_op_t   sel_op;
  logic [2:0] sel_idx;
  logic [7:0] sel_byte;
  logic       start_any, take_tx, take_rx, last_byte, reply_pass;
  logic       lim_hit;
  logic [CNT_W-1:0] lim;

  assign start_any = start_bus || start_ctrl;
  assign take_tx   = (state == ST_SEND) && tx_ready;
  assign take_rx   = (state == ST_RECV) && rx_valid;
  assign last_byte = (idx == ((op == OP_BUS) ? BUS_LAST : CTRL_LAST));
  assign reply_pass = (op == OP_BUS) ? |(rx_data & FLAG_MASK) : ~|(rx_data & BUSY_MASK);
  assign lim = (op == OP_BUS) ? CNT_W'(BUS_RETRIES) : CNT_W'(MAX_BUSY_POLLS);

  // which byte is loaded next into tx_data
  always_comb begin
    sel_op  = op;
    sel_idx = 3'd0;
    if (state == ST_IDLE) begin
      sel_op = start_bus ? OP_BUS : OP_CTRL;
    end else if (state == ST_SEND) begin
      sel_idx = idx + 3'd1;
    end
  end

  poll_frame_rom #(
    .OP_LDCS(OP_LDCS), .STATUS_IDX(STATUS_IDX), .OP_LDS(OP_LDS),
    .SIZE_CODE(SIZE_CODE), .DATA_BASE(DATA_BASE), .CTRL_BASE(CTRL_BASE),
    .STAT_OFS(STAT_OFS)
  ) u_rom (
    .op(sel_op), .idx(sel_idx), .byte_o(sel_byte)
  );

  poll_try_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst),
    .clr((state == ST_IDLE) && start_any),
    .inc(take_rx && !reply_pass),
    .limit(lim), .hit(lim_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op       <= OP_BUS;
      idx      <= 3'd0;
      tx_data  <= 8'h00;
      tx_valid <= 1'b0;
      rx_ready <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_any) begin
            op       <= sel_op;
            idx      <= 3'd0;
            tx_data  <= sel_byte;
            tx_valid <= 1'b1;
            busy     <= 1'b1;
            ok       <= 1'b0;
            timeout  <= 1'b0;
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (take_tx) begin
            if (last_byte) begin
              tx_valid <= 1'b0;
              rx_ready <= 1'b1;
              state    <= ST_RECV;
            end else begin
              idx     <= sel_idx;
              tx_data <= sel_byte;
            end
          end
        end
        ST_RECV: begin
          if (take_rx) begin
            rx_ready <= 1'b0;
            if (reply_pass || lim_hit) begin
              done    <= 1'b1;
              ok      <= reply_pass;
              timeout <= !reply_pass;
              busy    <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              idx      <= 3'd0;
              tx_data  <= sel_byte;
              tx_valid <= 1'b1;
              state    <= ST_SEND;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R10
  no_dir_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && rx_ready));

  // R10
  rx_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(tx_valid && tx_ready));

  // R11
  done_result_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok != timeout) && !busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  busy_op_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(op));
endmodule

// File: tb/sim_mem_poll_seq.sv
`timescale 1ns/1ps
module sim_mem_poll_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic start_bus = 1'b0, start_ctrl = 1'b0;
  logic [7:0] tx_data, rx_data = 8'h00;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic busy, done, ok, timeout;

  mem_poll_seq u0 (
    .clk(clk), .rst(rst), .start_bus(start_bus), .start_ctrl(start_ctrl),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .busy(busy), .done(done), .ok(ok), .timeout(timeout)
  );

  // second instance with a busy-poll limit of 3
  logic start1 = 1'b0;
  logic [7:0] tx_data1;
  logic tx_valid1, rx_ready1, busy1, done1, ok1, timeout1;
  mem_poll_seq #(.MAX_BUSY_POLLS(3)) u1 (
    .clk(clk), .rst(rst), .start_bus(1'b0), .start_ctrl(start1),
    .tx_data(tx_data1), .tx_valid(tx_valid1), .tx_ready(1'b1),
    .rx_data(8'hFF), .rx_valid(rx_ready1), .rx_ready(rx_ready1),
    .busy(busy1), .done(done1), .ok(ok1), .timeout(timeout1)
  );

  int checks = 0, errors = 0, cyc = 0, done_seen = 0, u1_bytes = 0;
  bit overlap = 1'b0, u1_done = 1'b0, u1_ok = 1'b0, u1_to = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] rsp_q[$];
  logic [1:0] exp_res[$];

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // link model: transmit acceptance pattern and reply delivery
  initial begin
    forever begin
      @(posedge clk); #1;
      tx_ready = (cyc % 3) != 1;
      if (rx_valid) rx_valid = 1'b0;
      else if (rx_ready && rsp_q.size() > 0 && cyc[0]) begin
        rx_data  = rsp_q.pop_front();
        rx_valid = 1'b1;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (tx_valid && rx_ready) overlap = 1'b1;
        if (tx_valid && tx_ready) begin
          if (exp_tx.size() == 0) chk(1'b0, "R8 unexpected byte", tx_data, 0);
          else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(tx_data == e, "R2/R5 byte", tx_data, e);
          end
        end
        if (done) begin
          done_seen++;
          if (exp_res.size() == 0) chk(1'b0, "R8 unexpected done", {ok, timeout}, 0);
          else begin
            logic [1:0] e;
            e = exp_res.pop_front();
            chk({ok, timeout} == e, "R3/R4/R6/R7 result", {ok, timeout}, e);
          end
        end
        if (tx_valid1) u1_bytes++;
        if (done1) begin u1_done = 1'b1; u1_ok = ok1; u1_to = timeout1; end
      end
    end
  end

  // is_ctrl: 0 enable poll, 1 busy poll
  task automatic run(input bit is_ctrl, input int n_fail, input logic [7:0] fail_b,
                     input bit pass, input logic [7:0] pass_b, input bit both, input bit poke);
    int prev = done_seen;
    int n = n_fail + (pass ? 1 : 0);
    for (int i = 0; i < n_fail; i++) rsp_q.push_back(fail_b);
    if (pass) rsp_q.push_back(pass_b);
    for (int i = 0; i < n; i++) begin
      if (!is_ctrl) exp_tx.push_back(8'h80);
      else begin
        exp_tx.push_back(8'h00); exp_tx.push_back(8'h01);
        exp_tx.push_back(8'h00); exp_tx.push_back(8'h01); exp_tx.push_back(8'hCF);
      end
    end
    exp_res.push_back(pass ? 2'b10 : 2'b01);
    @(posedge clk); #1;
    start_bus = !is_ctrl || both; start_ctrl = is_ctrl || both;
    @(posedge clk); #1;
    start_bus = 1'b0; start_ctrl = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(posedge clk); #1;
      start_ctrl = 1'b1; start_bus = 1'b1;
      @(posedge clk); #1;
      start_ctrl = 1'b0; start_bus = 1'b0;
    end
    wait (done_seen != prev);
    @(posedge clk); #1;
    chk(busy == 1'b0, "R8 idle after done", busy, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk); #1;
    rst = 1'b0;
    // R1
    chk({busy, tx_valid, rx_ready, done, ok, timeout} == 6'b0, "R1 reset",
        {busy, tx_valid, rx_ready, done, ok, timeout}, 0);
    // R7 limited instance
    start1 = 1'b1; @(posedge clk); #1; start1 = 1'b0;
    // R2 R3: flag-clear reply with other bits set, then flag
    run(1'b0, 2, 8'hFD, 1'b1, 8'h02, 1'b0, 1'b0);
    // R11: result held after done
    repeat (5) @(posedge clk); #1;
    chk(ok == 1'b1 && done == 1'b0, "R11 result held", {ok, done}, 2'b10);
    // R5 R6: busy replies then bit7 clear
    run(1'b1, 2, 8'h80, 1'b1, 8'h7F, 1'b0, 1'b0);
    // R7 unlimited with default
    run(1'b1, 300, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0);
    // R4 timeout, R8 starts while busy are ignored
    run(1'b0, 255, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    // R9 both starts together
    run(1'b0, 0, 8'h00, 1'b1, 8'h02, 1'b1, 1'b0);
    repeat (10) @(posedge clk); #1;
    chk(exp_tx.size() == 0, "R2/R5 all bytes sent", exp_tx.size(), 0);
    chk(exp_res.size() == 0, "R11 all results seen", exp_res.size(), 0);
    chk(!overlap, "R10 no tx/rx overlap", overlap, 0);
    chk(u1_done && u1_to && !u1_ok, "R7 limit timeout", {u1_done, u1_to, u1_ok}, 3'b110);
    chk(u1_bytes == 15, "R7 limit attempts", u1_bytes, 15);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule